// File: doc/BRIEF.md
# Timer Channel with Capture/Compare Buffering

This block is one timer channel built around a free-running counter and a set of general registers. Each primary general register either compares its value against the counter and raises a one-clock match pulse, or captures the counter value when its capture input rises. Every primary register has a partner buffer register. When buffering is enabled for a pair, the buffer double-buffers the primary. In capture mode it keeps the previous capture. In compare mode it supplies the next compare value, which is loaded into the primary on a match.

The counter advances on one of two count strobes: an internal prescaled tick or an external event. A control bit selects which one. Software reaches the counter, the control word and all general registers through a plain word-wide register bus. Reads are combinational. Writes take effect at the next clock edge and win over any hardware update of the same register in that cycle.

With the default parameters there are two pairs. Register A is paired with buffer C, and register B is paired with buffer D.

Top module: `tmr_chan`

## Requirements
- R1: After reset the counter reads 0000h, all four general registers read FFFFh, the control word reads 0 and both match outputs are low.
- R2: With control bit 0 clear, the counter counts `tick_i` and ignores `ext_ev_i`. With control bit 0 set, it counts `ext_ev_i` and ignores `tick_i`. Each selected strobe adds one. When no selected strobe is present, the counter holds its value.
- R3: The counter wraps from FFFFh to 0000h on an increment.
- R4: A bus write to the counter loads the written word, even when an increment arrives in the same cycle.
- R5: Bus addresses are fixed as follows.
  - 0 is the control word. Bit 0 selects the count source. Bit 1 is the A mode and bit 2 is the B mode (1 = capture). Bit 3 enables A/C buffering and bit 4 enables B/D buffering.
  - 1 is the counter.
  - 2 and 3 are A and B.
  - 4 and 5 are C and D.
  - Addresses 6 and 7 read 0.
  - Reads are combinational. Only whole 16-bit words are written.
- R6: In compare mode, the match output is high for exactly the one cycle in which the counter holds a value that an increment has just made equal to the register. A bus write to the counter never causes a match, and a register in capture mode never matches.
- R7: In capture mode, a capture input that was low in the previous cycle and is high now latches the counter value present in that cycle into the register. While the input stays high, no further captures occur.
- R8: In capture mode with buffering enabled, a capture also moves the old register value into its buffer register.
- R9: In compare mode with buffering enabled, a match copies the buffer value into the register at the same edge that raises the match output.
- R10: A bus write to a general register takes priority over a capture or buffer transfer into that register in the same cycle.
- R11: With buffering disabled, registers C and D are plain read/write storage that no capture or match changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register word address |
| bus_we | input | 1 | Write strobe for the addressed word |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data of the addressed word (combinational) |
| tick_i | input | 1 | Internal prescaled count strobe |
| ext_ev_i | input | 1 | External event count strobe |
| cap_i | input | 2 | Capture inputs; bit 0 for A, bit 1 for B |
| match_o | output | 2 | Compare match pulses; bit 0 for A, bit 1 for B |

## Verification
A counter that is off by one in value or timing appears on the next read of address 1. It also moves the cycle of the next match pulse, so the error is seen within one clock of the first increment that reaches a compare value. A buffer that shifts at the wrong time, or does not shift, shows up in the C or D read word at the next edge. In compare mode it shows up again later, as a wrong primary value and a missing or misplaced match pulse. The bench therefore compares both match outputs and the read word of the current address against a behavioural model on every clock. This catches a divergence in the cycle after it arises.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   localparam int ADDR_CTRL     = 0;
   localparam int ADDR_CNT      = 1;
   localparam int ADDR_PRI_BASE = 2;

   typedef enum logic {SRC_TICK = 1'b0, SRC_EVENT = 1'b1} cnt_src_e;

   function automatic int pri_addr(input int k);
      return ADDR_PRI_BASE + k;
   endfunction

   function automatic int buf_addr(input int k, input int npair);
      return ADDR_PRI_BASE + npair + k;
   endfunction

   function automatic int mode_bit(input int k);
      return 1 + k;
   endfunction

   function automatic int bufen_bit(input int k, input int npair);
      return 1 + npair + k;
   endfunction
endpackage

// File: rtl/tmr_counter.sv
module tmr_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             ev_i,
   input  tmr_pkg::cnt_src_e src_i,
   input  logic             wr_i,
   input  logic [CNT_W-1:0] wdata_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic [CNT_W-1:0] cnt_plus_o,
   output logic             inc_o
);
   logic [CNT_W-1:0] cnt_q;

   assign inc_o      = (src_i == tmr_pkg::SRC_EVENT) ? ev_i : tick_i;
   assign cnt_plus_o = cnt_q + CNT_W'(1);
   assign cnt_o      = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (wr_i)   cnt_q <= wdata_i;
      else if (inc_o)  cnt_q <= cnt_plus_o;
   end

   // R4
   a_r4_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
      wr_i |=> cnt_q == $past(wdata_i));
   // R3
   a_r3_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (inc_o && !wr_i && cnt_q == {CNT_W{1'b1}}) |=> cnt_q == '0);
   // R2
   a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_i && !ev_i && !wr_i) |=> $stable(cnt_q));
endmodule

// File: rtl/tmr_rise.sv
module tmr_rise (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic rise_o
);
   logic prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= d_i;
   end

   assign rise_o = d_i & ~prev_q;
endmodule

// File: rtl/tmr_pair.sv
module tmr_pair #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] cnt_i,
   input  logic [CNT_W-1:0] cnt_plus_i,
   input  logic             inc_i,
   input  logic             cnt_wr_i,
   input  logic             cap_rise_i,
   input  logic             cap_mode_i,
   input  logic             buf_en_i,
   input  logic             wr_pri_i,
   input  logic             wr_buf_i,
   input  logic [CNT_W-1:0] wdata_i,
   output logic [CNT_W-1:0] pri_o,
   output logic [CNT_W-1:0] buf_o,
   output logic             match_o
);
   logic [CNT_W-1:0] pri_q, buf_q;
   logic             match_q;
   logic             hit, take_cap;

   // compare against the value the counter is about to take
   assign hit      = !cap_mode_i && inc_i && !cnt_wr_i && (cnt_plus_i == pri_q);
   assign take_cap = cap_mode_i && cap_rise_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 pri_q <= '1;
      else if (wr_pri_i)          pri_q <= wdata_i;
      else if (take_cap)          pri_q <= cnt_i;
      else if (hit && buf_en_i)   pri_q <= buf_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    buf_q <= '1;
      else if (wr_buf_i)             buf_q <= wdata_i;
      else if (take_cap && buf_en_i) buf_q <= pri_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) match_q <= 1'b0;
      else        match_q <= hit;
   end

   assign pri_o   = pri_q;
   assign buf_o   = buf_q;
   assign match_o = match_q;

   // R6
   a_r6_match_value: assert property (@(posedge clk) disable iff (!rst_n)
      match_q |-> cnt_i == $past(pri_q));
   // R7
   a_r7_capture: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_rise_i && cap_mode_i && !wr_pri_i) |=> pri_q == $past(cnt_i));
   // R8
   a_r8_buf_shift: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_rise_i && cap_mode_i && buf_en_i && !wr_buf_i) |=> buf_q == $past(pri_q));
   // R9
   a_r9_buf_load: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && buf_en_i && !wr_pri_i) |=> pri_q == $past(buf_q));
   // R10
   a_r10_bus_wins: assert property (@(posedge clk) disable iff (!rst_n)
      wr_pri_i |=> pri_q == $past(wdata_i));
   // R11
   a_r11_buf_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!buf_en_i && !wr_buf_i) |=> $stable(buf_q));
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs #(
   parameter int CNT_W  = 16,
   parameter int NPAIR  = 2,
   parameter int ADDR_W = 3
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [ADDR_W-1:0]           addr_i,
   input  logic                        we_i,
   input  logic [CNT_W-1:0]            wdata_i,
   input  logic [CNT_W-1:0]            cnt_i,
   input  logic [NPAIR-1:0][CNT_W-1:0] pri_i,
   input  logic [NPAIR-1:0][CNT_W-1:0] buf_i,
   output tmr_pkg::cnt_src_e           src_o,
   output logic [NPAIR-1:0]            mode_o,
   output logic [NPAIR-1:0]            bufen_o,
   output logic                        cnt_wr_o,
   output logic [NPAIR-1:0]            pri_wr_o,
   output logic [NPAIR-1:0]            buf_wr_o,
   output logic [CNT_W-1:0]            rdata_o
);
   localparam int CTRL_W = 1 + 2 * NPAIR;

   logic [CTRL_W-1:0] ctrl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ctrl_q <= '0;
      else if (we_i && addr_i == ADDR_W'(tmr_pkg::ADDR_CTRL))
         ctrl_q <= wdata_i[CTRL_W-1:0];
   end

   assign src_o    = tmr_pkg::cnt_src_e'(ctrl_q[0]);
   assign cnt_wr_o = we_i && addr_i == ADDR_W'(tmr_pkg::ADDR_CNT);

   for (genvar k = 0; k < NPAIR; k++) begin : g_dec
      assign mode_o[k]   = ctrl_q[tmr_pkg::mode_bit(k)];
      assign bufen_o[k]  = ctrl_q[tmr_pkg::bufen_bit(k, NPAIR)];
      assign pri_wr_o[k] = we_i && addr_i == ADDR_W'(tmr_pkg::pri_addr(k));
      assign buf_wr_o[k] = we_i && addr_i == ADDR_W'(tmr_pkg::buf_addr(k, NPAIR));
   end

   always_comb begin
      rdata_o = '0;
      if (addr_i == ADDR_W'(tmr_pkg::ADDR_CTRL)) rdata_o = CNT_W'(ctrl_q);
      if (addr_i == ADDR_W'(tmr_pkg::ADDR_CNT))  rdata_o = cnt_i;
      for (int k = 0; k < NPAIR; k++) begin
         if (addr_i == ADDR_W'(tmr_pkg::pri_addr(k)))        rdata_o = pri_i[k];
         if (addr_i == ADDR_W'(tmr_pkg::buf_addr(k, NPAIR))) rdata_o = buf_i[k];
      end
   end

   // R5
   a_r5_one_write: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({cnt_wr_o, pri_wr_o, buf_wr_o}) <= 1);
   a_r5_ctrl_stable: assert property (@(posedge clk) disable iff (!rst_n)
      !(we_i && addr_i == ADDR_W'(tmr_pkg::ADDR_CTRL)) |=> $stable(ctrl_q));
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan #(
   parameter int CNT_W  = 16,
   parameter int NPAIR  = 2,
   parameter int ADDR_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [CNT_W-1:0]  bus_wdata,
   output logic [CNT_W-1:0]  bus_rdata,
   input  logic              tick_i,
   input  logic              ext_ev_i,
   input  logic [NPAIR-1:0]  cap_i,
   output logic [NPAIR-1:0]  match_o
);
   localparam int NWORDS = tmr_pkg::ADDR_PRI_BASE + 2 * NPAIR;
   localparam int CTRL_W = 1 + 2 * NPAIR;

   if (NPAIR < 1) begin : g_bad_npair
      $error("tmr_chan: NPAIR must be at least 1");
   end
   if (CNT_W < CTRL_W) begin : g_bad_width
      $error("tmr_chan: CNT_W too narrow for the control word");
   end
   if ((1 << ADDR_W) < NWORDS) begin : g_bad_addr
      $error("tmr_chan: ADDR_W too small for the register map");
   end

   tmr_pkg::cnt_src_e          src;
   logic [NPAIR-1:0]           mode, bufen, pri_wr, buf_wr, rise;
   logic                       cnt_wr, inc;
   logic [CNT_W-1:0]           cnt, cnt_plus;
   logic [NPAIR-1:0][CNT_W-1:0] pri, bufr;

   tmr_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .ev_i(ext_ev_i),
      .src_i(src), .wr_i(cnt_wr), .wdata_i(bus_wdata),
      .cnt_o(cnt), .cnt_plus_o(cnt_plus), .inc_o(inc));

   tmr_regs #(.CNT_W(CNT_W), .NPAIR(NPAIR), .ADDR_W(ADDR_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .addr_i(bus_addr), .we_i(bus_we),
      .wdata_i(bus_wdata), .cnt_i(cnt), .pri_i(pri), .buf_i(bufr),
      .src_o(src), .mode_o(mode), .bufen_o(bufen), .cnt_wr_o(cnt_wr),
      .pri_wr_o(pri_wr), .buf_wr_o(buf_wr), .rdata_o(bus_rdata));

   for (genvar k = 0; k < NPAIR; k++) begin : g_pair
      tmr_rise u_rise (
         .clk(clk), .rst_n(rst_n), .d_i(cap_i[k]), .rise_o(rise[k]));

      tmr_pair #(.CNT_W(CNT_W)) u_pair (
         .clk(clk), .rst_n(rst_n), .cnt_i(cnt), .cnt_plus_i(cnt_plus),
         .inc_i(inc), .cnt_wr_i(cnt_wr), .cap_rise_i(rise[k]),
         .cap_mode_i(mode[k]), .buf_en_i(bufen[k]), .wr_pri_i(pri_wr[k]),
         .wr_buf_i(buf_wr[k]), .wdata_i(bus_wdata), .pri_o(pri[k]),
         .buf_o(bufr[k]), .match_o(match_o[k]));
   end

   // R1
   a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!rst_n) |-> match_o == '0);
endmodule

// File: tb/tmr_chan_test.sv
`timescale 1ns/1ps
module tmr_chan_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic        bus_we = 1'b0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic        tick_i = 1'b0;
   logic        ext_ev_i = 1'b0;
   logic [1:0]  cap_i = '0;
   logic [1:0]  match_o;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   int m_cnt, m_ctrl;
   int m_pri[2];
   int m_buf[2];
   bit m_prev[2];
   bit m_match[2];

   always #10 clk = ~clk;

   tmr_chan uut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_i(tick_i),
      .ext_ev_i(ext_ev_i), .cap_i(cap_i), .match_o(match_o));

   function automatic int model_read(input int a);
      case (a)
         0: return m_ctrl;
         1: return m_cnt;
         2: return m_pri[0];
         3: return m_pri[1];
         4: return m_buf[0];
         5: return m_buf[1];
         default: return 0;
      endcase
   endfunction

   task automatic model_step(input int a, input bit we, input int wd,
                             input bit tk, input bit ev, input bit [1:0] cp);
      bit inc   = m_ctrl[0] ? ev : tk;
      bit wcnt  = we && a == 1;
      int nxt   = (m_cnt + 1) & 16'hFFFF;
      int o_pri[2];
      int o_buf[2];
      o_pri = m_pri;
      o_buf = m_buf;
      for (int k = 0; k < 2; k++) begin
         bit rise = cp[k] && !m_prev[k];
         bit capm = m_ctrl[1 + k];
         bit be   = m_ctrl[3 + k];
         bit hit  = !capm && inc && !wcnt && nxt == o_pri[k];
         if (capm && rise) begin
            m_pri[k] = m_cnt;
            if (be) m_buf[k] = o_pri[k];
         end
         if (hit && be) m_pri[k] = o_buf[k];
         if (we && a == 2 + k) m_pri[k] = wd & 16'hFFFF;
         if (we && a == 4 + k) m_buf[k] = wd & 16'hFFFF;
         m_match[k] = hit;
         m_prev[k]  = cp[k];
      end
      if (wcnt)     m_cnt = wd & 16'hFFFF;
      else if (inc) m_cnt = nxt;
      if (we && a == 0) m_ctrl = wd & 'h1F;
   endtask

   task automatic check(input string tag, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic cyc(input string tag, input int a, input bit we, input int wd,
                      input bit tk, input bit ev, input bit [1:0] cp);
      bus_addr  = a[2:0];
      bus_we    = we;
      bus_wdata = wd[15:0];
      tick_i    = tk;
      ext_ev_i  = ev;
      cap_i     = cp;
      model_step(a, we, wd, tk, ev, cp);
      @(negedge clk);
      check(tag, "match_a", int'(match_o[0]), int'(m_match[0]));
      check(tag, "match_b", int'(match_o[1]), int'(m_match[1]));
      check(tag, "rdata", int'(bus_rdata), model_read(a));
   endtask

   task automatic wr(input string tag, input int a, input int wd);
      cyc(tag, a, 1'b1, wd, 1'b0, 1'b0, cap_i);
   endtask

   // literal expectation, independent of the model
   task automatic expect_rd(input string tag, input int a, input int exp);
      bus_addr = a[2:0];
      bus_we   = 1'b0;
      tick_i   = 1'b0;
      ext_ev_i = 1'b0;
      #1;
      check(tag, "read", int'(bus_rdata), exp);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL R1 watchdog actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      m_cnt = 0; m_ctrl = 0;
      for (int k = 0; k < 2; k++) begin
         m_pri[k] = 16'hFFFF; m_buf[k] = 16'hFFFF; m_prev[k] = 0; m_match[k] = 0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state, R5 map
      for (int a = 0; a < 8; a++) cyc("R1", a, 1'b0, 0, 1'b0, 1'b0, 2'b00);
      expect_rd("R1", 1, 0);
      expect_rd("R1", 2, 16'hFFFF);
      expect_rd("R1", 5, 16'hFFFF);
      expect_rd("R5", 6, 0);

      // R6 compare on tick
      wr("R5", 0, 0);
      wr("R5", 2, 5);
      wr("R5", 1, 2);
      for (int i = 0; i < 4; i++) cyc("R6", 1, 1'b0, 0, 1'b1, 1'b0, 2'b00);
      expect_rd("R6", 1, 6);

      // R2 event ignored while tick selected
      for (int i = 0; i < 3; i++) cyc("R2", 1, 1'b0, 0, 1'b0, 1'b1, 2'b00);
      expect_rd("R2", 1, 6);
      wr("R2", 0, 1);
      for (int i = 0; i < 2; i++) cyc("R2", 1, 1'b0, 0, 1'b0, 1'b1, 2'b00);
      for (int i = 0; i < 2; i++) cyc("R2", 1, 1'b0, 0, 1'b1, 1'b0, 2'b00);
      expect_rd("R2", 1, 8);

      // R3 wrap
      wr("R3", 1, 16'hFFFE);
      for (int i = 0; i < 3; i++) cyc("R3", 1, 1'b0, 0, 1'b0, 1'b1, 2'b00);
      expect_rd("R3", 1, 1);

      // R4 write beats increment
      cyc("R4", 1, 1'b1, 16'h0100, 1'b0, 1'b1, 2'b00);
      expect_rd("R4", 1, 16'h0100);

      // R6 a written counter value equal to A gives no match
      cyc("R6", 1, 1'b1, 5, 1'b0, 1'b1, 2'b00);
      check("R6", "no_match_on_write", int'(match_o[0]), 0);
      cyc("R6", 1, 1'b0, 0, 1'b0, 1'b1, 2'b00);

      // R7 capture on rising edge only
      wr("R7", 0, 3);
      wr("R7", 1, 16'h0020);
      cyc("R7", 2, 1'b0, 0, 1'b0, 1'b0, 2'b01);
      cyc("R7", 2, 1'b0, 0, 1'b0, 1'b1, 2'b01);
      cyc("R7", 2, 1'b0, 0, 1'b0, 1'b1, 2'b01);
      expect_rd("R7", 2, 16'h0020);
      cyc("R7", 2, 1'b0, 0, 1'b0, 1'b0, 2'b00);

      // R8 buffered capture
      wr("R8", 0, 16'h000B);
      wr("R8", 1, 16'h0030);
      cyc("R8", 4, 1'b0, 0, 1'b0, 1'b0, 2'b01);
      expect_rd("R8", 4, 16'h0020);
      expect_rd("R8", 2, 16'h0030);
      cyc("R8", 4, 1'b0, 0, 1'b0, 1'b0, 2'b00);

      // R9 buffered compare on B
      wr("R9", 0, 16'h0011);
      wr("R9", 3, 16'h0040);
      wr("R9", 5, 16'h0050);
      wr("R9", 1, 16'h003E);
      for (int i = 0; i < 3; i++) cyc("R9", 3, 1'b0, 0, 1'b0, 1'b1, 2'b00);
      expect_rd("R9", 3, 16'h0050);

      // R10 bus write beats capture
      wr("R10", 0, 3);
      cyc("R10", 2, 1'b1, 16'h1234, 1'b0, 1'b0, 2'b01);
      expect_rd("R10", 2, 16'h1234);
      cyc("R10", 2, 1'b0, 0, 1'b0, 1'b0, 2'b00);

      // R11 C and D untouched without buffering
      wr("R11", 4, 16'h7777);
      wr("R11", 5, 16'h9999);
      cyc("R11", 4, 1'b0, 0, 1'b0, 1'b0, 2'b01);
      expect_rd("R11", 4, 16'h7777);
      wr("R11", 1, 16'h004F);
      cyc("R11", 3, 1'b0, 0, 1'b0, 1'b1, 2'b00);
      check("R11", "match_b", int'(match_o[1]), 1);
      expect_rd("R11", 3, 16'h0050);
      expect_rd("R11", 5, 16'h9999);

      // mixed stimulus against the model
      for (int i = 0; i < 400; i++) begin
         int a  = int'($urandom_range(0, 7));
         bit we = ($urandom_range(0, 7) == 0);
         int wd = int'($urandom_range(0, 65535));
         if (a == 1 && we) wd = wd & 16'h000F;
         cyc("R5", a, we, wd, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
             2'($urandom_range(0, 3)));
      end

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule